// File: doc/BRIEF.md
# PHY-to-Link Status Transfer Engine

This block delivers status words from the physical layer to the link controller over the shared interface lines: a 2-bit control bus and a 4-bit data bus. Events such as gap detections, bus reset and timeout or cable-power trouble are raised as one-cycle flag pulses. Register reports come from a read request or from the end of self-identification. All of these collect in a pending store. When the interface is free, the engine marks a status transfer on the control lines and shifts the word out two bits per clock.

Most transfers carry only the four flag bits and take two clocks. A register report carries flags, a 4-bit register address and 8 bits of register data, and takes eight clocks. An incoming packet can preempt a transfer at any beat. The engine then drops the transfer at once and later resends the same latched word from its first bit. Consecutive transfers are always separated by a programmable number of quiet clocks.

Top module: `status_xfer_engine`

## Requirements
- R1: After reset `ctl` = 00, `d` = 0000, and nothing is pending, so no transfer starts until a new event arrives.
- R2: A flag-only transfer drives `ctl` = 01 for exactly 2 consecutive clocks. Word bit i is set by `flag_evt[i]`: bit 0 arbitration-reset gap, bit 1 subaction gap, bit 2 bus reset, bit 3 timeout or cable power.
- R3: A register report drives `ctl` = 01 for exactly 8 clocks with word bits [3:0] flags, [7:4] address, [15:8] data. Beat k carries bit 2k on `d[0]` and bit 2k+1 on `d[1]`, and the first beat appears in the same clock that `ctl` first shows 01.
- R4: `selfid_done` queues a register report with address 0 and data equal to `node_id` zero-extended. When it coincides with `report_req`, the self-ID report wins.
- R5: A transfer starts only on a clock edge where `link_idle` = 1 and `rx_preempt` = 0. Otherwise pending work waits with `ctl` = 00.
- R6: `rx_preempt` = 1 during a transfer beat abandons it, so `ctl` = 00 on the next clock. The transfer is then retried from S0 with the same latched word, and events arriving meanwhile do not alter that word.
- R7: At least GAP_CYCLES (default 1) clocks with `ctl` = 00 separate any two transfers. When work is waiting and the link is idle, the next transfer starts after exactly GAP_CYCLES quiet clocks.
- R8: Flag events accumulate by OR while waiting and merge into one word. Flags raised in the clock a word is latched, or during a transfer, go to the next word. A newer register report replaces an older pending one.
- R9: `d[3:2]` stay 0 during a transfer, and both `ctl` and `d` are all-zero outside transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_evt | input | 4 | One-cycle flag event pulses, bit i sets status bit i |
| report_req | input | 1 | Request to report a register |
| report_addr | input | 4 | Address of the register to report |
| report_data | input | 8 | Contents of the register to report |
| selfid_done | input | 1 | Self-identification finished; report the node ID |
| node_id | input | 6 | Node ID to report after self-identification |
| link_idle | input | 1 | Shared interface lines are free |
| rx_preempt | input | 1 | Incoming packet claims the lines |
| ctl | output | 2 | Control lines: 01 during a status transfer, else 00 |
| d | output | 4 | Data lines carrying two status bits per clock |

## Verification
The hardest situation to reach is a preemption landing mid-word while new flags and a new register report arrive during the abort gap. The retry must then resend the old word unchanged, and the newcomers must follow as a separate, merged transfer. Directed stimulus waits for the data lines to show the third beat of a report, raises `rx_preempt` for exactly one clock, and pulses every flag in the gap clock. A long pseudo-random phase then mixes busy links, preemptions at every beat position and overlapping requests against a behavioural model compared on every clock.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEND = 2'd1,
    PH_GAP  = 2'd2
  } stx_phase_e;

  // number of clock beats needed to move a bit count over a lane count
  function automatic int unsigned beats_for(input int unsigned nbits, input int unsigned lanes);
    return (nbits + lanes - 1) / lanes;
  endfunction

  // counter width that can index values 0..n-1 (at least one bit)
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/stx_pending.sv
module stx_pending #(
  parameter int unsigned FLAG_W = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ID_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flag_evt,
  input  logic              report_req,
  input  logic [ADDR_W-1:0] report_addr,
  input  logic [DATA_W-1:0] report_data,
  input  logic              selfid_done,
  input  logic [ID_W-1:0]   node_id,
  input  logic              take,
  output logic [FLAG_W-1:0] pend_flags,
  output logic              pend_full,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data,
  output logic              has_work
);

  localparam int unsigned PAD_W = DATA_W - ID_W;

  logic [DATA_W-1:0] id_as_data;

  generate
    if (PAD_W > 0) begin : g_pad
      assign id_as_data = {{PAD_W{1'b0}}, node_id};
    end else begin : g_nopad
      assign id_as_data = DATA_W'(node_id);
    end
  endgenerate

  // flags merge by OR; a word taken this cycle leaves only new arrivals
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_flags <= '0;
    end else begin
      pend_flags <= (take ? '0 : pend_flags) | flag_evt;
    end
  end

  // one register report slot; the newest request replaces an older one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (selfid_done) begin
      pend_full <= 1'b1;
      pend_addr <= '0;
      pend_data <= id_as_data;
    end else if (report_req) begin
      pend_full <= 1'b1;
      pend_addr <= report_addr;
      pend_data <= report_data;
    end else if (take) begin
      pend_full <= 1'b0;
    end
  end

  assign has_work = pend_full || (|pend_flags);

endmodule

// File: rtl/stx_sequencer.sv
module stx_sequencer
  import stx_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned FLAG_W     = 4,
  parameter int unsigned LANES      = 2,
  parameter int unsigned GAP_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_work,
  input  logic [WORD_W-1:0] new_word,
  input  logic              new_full,
  input  logic              link_idle,
  input  logic              rx_preempt,
  output logic              take,
  output logic              sending,
  output logic [LANES-1:0]  lane_bits,
  output logic              launch,
  output logic              abort
);

  localparam int unsigned FULL_BEATS  = beats_for(WORD_W, LANES);
  localparam int unsigned SHORT_BEATS = beats_for(FLAG_W, LANES);
  localparam int unsigned BEAT_W      = idx_width(FULL_BEATS);
  localparam int unsigned GAP_W       = idx_width(GAP_CYCLES);
  localparam logic [BEAT_W-1:0] FULL_LAST  = BEAT_W'(FULL_BEATS - 1);
  localparam logic [BEAT_W-1:0] SHORT_LAST = BEAT_W'(SHORT_BEATS - 1);
  localparam logic [GAP_W-1:0]  GAP_LAST   = GAP_W'(GAP_CYCLES - 1);

  stx_phase_e        phase;
  logic [BEAT_W-1:0] beat;
  logic [GAP_W-1:0]  gap_cnt;
  logic [WORD_W-1:0] word;
  logic              full;
  logic              retry;

  logic              gap_done;
  logic              ready;
  logic              go;
  logic              finish;
  logic [BEAT_W-1:0] last_beat;

  always_comb begin
    last_beat = full ? FULL_LAST : SHORT_LAST;
    gap_done  = (phase == PH_GAP) && (gap_cnt == GAP_LAST);
    ready     = (phase == PH_IDLE) || gap_done;
    go        = ready && (retry || pend_work) && link_idle && !rx_preempt;
    take      = go && !retry;
    abort     = (phase == PH_SEND) && rx_preempt;
    finish    = (phase == PH_SEND) && !rx_preempt && (beat == last_beat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      beat    <= '0;
      gap_cnt <= '0;
      word    <= '0;
      full    <= 1'b0;
      retry   <= 1'b0;
    end else if (go) begin
      phase <= PH_SEND;
      beat  <= '0;
      if (!retry) begin
        word <= new_word;
        full <= new_full;
      end
    end else begin
      unique case (phase)
        PH_SEND: begin
          if (abort) begin
            phase   <= PH_GAP;
            gap_cnt <= '0;
            retry   <= 1'b1;
          end else if (finish) begin
            phase   <= PH_GAP;
            gap_cnt <= '0;
            retry   <= 1'b0;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        PH_GAP: begin
          if (gap_done) phase <= PH_IDLE;
          else          gap_cnt <= gap_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // beat selector over the latched word
  always_comb begin
    lane_bits = '0;
    for (int k = 0; k < int'(FULL_BEATS); k++) begin
      if (beat == BEAT_W'(k)) lane_bits = word[k*LANES +: LANES];
    end
  end

  assign sending = (phase == PH_SEND);
  assign launch  = sending && (beat == '0);

endmodule

// File: rtl/status_xfer_engine.sv
module status_xfer_engine #(
  parameter int unsigned FLAG_W     = 4,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ID_W       = 6,
  parameter int unsigned LANES      = 2,
  parameter int unsigned DBUS_W     = 4,
  parameter int unsigned GAP_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flag_evt,
  input  logic              report_req,
  input  logic [ADDR_W-1:0] report_addr,
  input  logic [DATA_W-1:0] report_data,
  input  logic              selfid_done,
  input  logic [ID_W-1:0]   node_id,
  input  logic              link_idle,
  input  logic              rx_preempt,
  output logic [1:0]        ctl,
  output logic [DBUS_W-1:0] d
);

  localparam int unsigned WORD_W = FLAG_W + ADDR_W + DATA_W;
  localparam logic [1:0]  CTL_QUIET  = 2'b00;
  localparam logic [1:0]  CTL_STATUS = 2'b01;

  logic [FLAG_W-1:0] pend_flags;
  logic              pend_full;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              has_work;
  logic              take;
  logic              sending;
  logic [LANES-1:0]  lane_bits;

  // named internal events, observed by the bound checker
  logic              xfer_launch;
  logic              xfer_abort;

  stx_pending #(
    .FLAG_W(FLAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_pend (
    .clk(clk), .rst_n(rst_n),
    .flag_evt(flag_evt), .report_req(report_req),
    .report_addr(report_addr), .report_data(report_data),
    .selfid_done(selfid_done), .node_id(node_id),
    .take(take),
    .pend_flags(pend_flags), .pend_full(pend_full),
    .pend_addr(pend_addr), .pend_data(pend_data),
    .has_work(has_work)
  );

  stx_sequencer #(
    .WORD_W(WORD_W), .FLAG_W(FLAG_W), .LANES(LANES), .GAP_CYCLES(GAP_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .pend_work(has_work),
    .new_word({pend_data, pend_addr, pend_flags}),
    .new_full(pend_full),
    .link_idle(link_idle), .rx_preempt(rx_preempt),
    .take(take), .sending(sending), .lane_bits(lane_bits),
    .launch(xfer_launch), .abort(xfer_abort)
  );

  assign ctl = sending ? CTL_STATUS : CTL_QUIET;

  generate
    if (DBUS_W > LANES) begin : g_wide
      assign d = sending ? {{(DBUS_W-LANES){1'b0}}, lane_bits} : '0;
    end else begin : g_narrow
      assign d = sending ? lane_bits[DBUS_W-1:0] : '0;
    end
  endgenerate

endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
  parameter int unsigned DBUS_W      = 4,
  parameter int unsigned LANES       = 2,
  parameter int unsigned GAP_CYCLES  = 1,
  parameter int unsigned SHORT_BEATS = 2,
  parameter int unsigned FULL_BEATS  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ctl,
  input logic [DBUS_W-1:0] d,
  input logic              link_idle,
  input logic              rx_preempt,
  input logic              xfer_launch,
  input logic              xfer_abort
);

  logic [15:0] idle_run;
  logic [15:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_run <= 16'(GAP_CYCLES);
      run_cnt  <= '0;
    end else begin
      if (ctl == 2'b01) begin
        idle_run <= '0;
        run_cnt  <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
        if (idle_run < 16'(GAP_CYCLES)) idle_run <= idle_run + 1'b1;
      end
    end
  end

  // R9
  upper_lanes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d[DBUS_W-1:LANES] == '0);

  // R9
  quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl != 2'b01) |-> (d == '0));

  // R2
  ctl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == 2'b00) || (ctl == 2'b01));

  // R7
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_launch |-> (idle_run >= 16'(GAP_CYCLES)));

  // R5
  start_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_launch |-> ($past(link_idle) && !$past(rx_preempt)));

  // R6
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> (ctl == 2'b00));

  // R2 and R3: an unpreempted transfer is short or full length
  xfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl != 2'b01) && (run_cnt != '0) && !$past(rx_preempt))
      |-> ((run_cnt == 16'(SHORT_BEATS)) || (run_cnt == 16'(FULL_BEATS))));

endmodule

bind status_xfer_engine stx_checker #(
  .DBUS_W(DBUS_W),
  .LANES(LANES),
  .GAP_CYCLES(GAP_CYCLES),
  .SHORT_BEATS((FLAG_W + LANES - 1) / LANES),
  .FULL_BEATS((FLAG_W + ADDR_W + DATA_W + LANES - 1) / LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .d(d),
  .link_idle(link_idle), .rx_preempt(rx_preempt),
  .xfer_launch(xfer_launch), .xfer_abort(xfer_abort)
);

// File: tb/status_xfer_engine_tb.sv
`timescale 1ns/1ps
module status_xfer_engine_tb;

  localparam int GAP = 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] flag_evt;
  logic       report_req;
  logic [3:0] report_addr;
  logic [7:0] report_data;
  logic       selfid_done;
  logic [5:0] node_id;
  logic       link_idle;
  logic       rx_preempt;
  logic [1:0] ctl;
  logic [3:0] d;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  status_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .flag_evt(flag_evt),
    .report_req(report_req), .report_addr(report_addr), .report_data(report_data),
    .selfid_done(selfid_done), .node_id(node_id),
    .link_idle(link_idle), .rx_preempt(rx_preempt),
    .ctl(ctl), .d(d)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_ph;     // 0 quiet, 1 sending, 2 gap
  int          m_pos, m_g, m_len;
  logic [15:0] m_word;
  bit          m_retry, m_pfull;
  logic [3:0]  m_pf, m_pa;
  logic [7:0]  m_pd;

  always @(posedge clk) begin : mdl
    bit rdy, work, latched;
    if (!rst_n) begin
      m_ph = 0; m_pos = 0; m_g = 0; m_len = 2; m_word = '0;
      m_retry = 0; m_pfull = 0; m_pf = '0; m_pa = '0; m_pd = '0;
    end else begin
      rdy = (m_ph == 0) || (m_ph == 2 && m_g == GAP - 1);
      work = m_retry || (m_pf != 0) || m_pfull;
      latched = 0;
      if (m_ph == 1) begin
        if (rx_preempt) begin m_ph = 2; m_g = 0; m_retry = 1; end
        else if (m_pos == m_len - 1) begin m_ph = 2; m_g = 0; m_retry = 0; end
        else m_pos++;
      end else if (rdy && work && link_idle && !rx_preempt) begin
        m_ph = 1; m_pos = 0;
        if (!m_retry) begin
          m_word = {m_pd, m_pa, m_pf};
          m_len = m_pfull ? 8 : 2;
          latched = 1;
        end
      end else if (m_ph == 2) begin
        if (m_g == GAP - 1) m_ph = 0; else m_g++;
      end
      if (latched) begin m_pf = '0; m_pfull = 0; end
      m_pf = m_pf | flag_evt;
      if (selfid_done) begin m_pfull = 1; m_pa = '0; m_pd = {2'b00, node_id}; end
      else if (report_req) begin m_pfull = 1; m_pa = report_addr; m_pd = report_data; end
    end
  end

  always @(negedge clk) begin : cmp
    logic [1:0] ec;
    logic [3:0] ed;
    string tag;
    if (rst_n && !done) begin
      ec = (m_ph == 1) ? 2'b01 : 2'b00;
      ed = (m_ph == 1) ? {2'b00, 2'((m_word >> (2 * m_pos)) & 16'h3)} : 4'h0;
      tag = (m_ph == 1) ? ((m_len == 8) ? "R3" : "R2") : "R7";
      check(ctl === ec && d === ed, tag, "per-cycle ctl/d vs model",
            {26'd0, ctl, d}, {26'd0, ec, ed});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R5 watchdog expired: actual hung expected finished");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input logic [3:0] f, input bit rq, input logic [3:0] a,
                       input logic [7:0] dd, input bit sid, input logic [5:0] id);
    flag_evt = f; report_req = rq; report_addr = a; report_data = dd;
    selfid_done = sid; node_id = id;
    @(negedge clk);
    flag_evt = '0; report_req = 0; selfid_done = 0;
  endtask

  // collect one transfer; call at a negedge; returns at the first quiet negedge
  task automatic grab(input int max_wait, output logic [15:0] bits,
                      output int n, output int idle_n);
    bits = '0; n = 0; idle_n = 0;
    while (ctl !== 2'b01 && idle_n < max_wait) begin
      idle_n++;
      @(negedge clk);
    end
    while (ctl === 2'b01 && n < 8) begin
      bits[2*n +: 2] = d[1:0];
      check(d[3:2] == 2'b00, "R9", "upper data lanes during transfer", {30'd0, d[3:2]}, 0);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] b;
    int n, idl;
    rst_n = 0; flag_evt = '0; report_req = 0; report_addr = '0; report_data = '0;
    selfid_done = 0; node_id = '0; link_idle = 1; rx_preempt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ctl == 2'b00 && d == 4'h0, "R1", "reset state ctl/d", {26'd0, ctl, d}, 0);
    repeat (3) @(negedge clk);
    check(ctl == 2'b00, "R1", "no transfer without events", {30'd0, ctl}, 0);

    // short flag transfer
    drive(4'b1001, 0, 0, 0, 0, 0);
    grab(20, b, n, idl);
    check(n == 2, "R2", "short transfer length", n, 2);
    check(b[3:0] == 4'b1001, "R2", "short transfer flags", b[3:0], 4'b1001);

    // full register report
    repeat (3) @(negedge clk);
    drive(4'b0000, 1, 4'h6, 8'h3C, 0, 0);
    grab(20, b, n, idl);
    check(n == 8, "R3", "full transfer length", n, 8);
    check(b == 16'h3C60, "R3", "full transfer word", b, 16'h3C60);

    // self-ID report beats a simultaneous register request
    repeat (3) @(negedge clk);
    drive(4'b0000, 1, 4'h5, 8'h77, 1, 6'h2B);
    grab(20, b, n, idl);
    check(n == 8, "R4", "self-ID transfer length", n, 8);
    check(b == 16'h2B00, "R4", "self-ID word", b, 16'h2B00);

    // busy link holds the transfer back
    repeat (3) @(negedge clk);
    link_idle = 0;
    drive(4'b0100, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      check(ctl == 2'b00, "R5", "no transfer while link busy", {30'd0, ctl}, 0);
      @(negedge clk);
    end
    link_idle = 1;
    grab(20, b, n, idl);
    check(n == 2 && b[3:0] == 4'b0100, "R5", "transfer after link frees", {b[15:0], 8'(n)}, {16'h0004, 8'd2});

    // merging while waiting
    repeat (3) @(negedge clk);
    link_idle = 0;
    drive(4'b0001, 0, 0, 0, 0, 0);
    drive(4'b0010, 0, 0, 0, 0, 0);
    drive(4'b1000, 0, 0, 0, 0, 0);
    link_idle = 1;
    grab(20, b, n, idl);
    check(b[3:0] == 4'b1011, "R8", "merged flags", b[3:0], 4'b1011);
    grab(10, b, n, idl);
    check(n == 0, "R8", "no leftover transfer after merge", n, 0);

    // back-to-back: flags raised at latch go to next word, exact gap
    drive(4'b0000, 1, 4'h2, 8'h81, 0, 0);
    drive(4'b0001, 0, 0, 0, 0, 0);
    grab(20, b, n, idl);
    check(b == 16'h8120 && n == 8, "R8", "first word excludes late flag", b, 16'h8120);
    grab(20, b, n, idl);
    check(idl == GAP, "R7", "quiet clocks between transfers", idl, GAP);
    check(b[3:0] == 4'b0001 && n == 2, "R8", "late flag in next word", b[3:0], 4'b0001);

    // preemption mid-word, retry with the same word
    repeat (3) @(negedge clk);
    drive(4'b0000, 1, 4'h9, 8'hC3, 0, 0);
    while (ctl !== 2'b01) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rx_preempt = 1;
    @(negedge clk);
    rx_preempt = 0;
    check(ctl == 2'b00, "R6", "lines released after preempt", {30'd0, ctl}, 0);
    flag_evt = 4'hF; report_req = 1; report_addr = 4'h1; report_data = 8'h11;
    @(negedge clk);
    flag_evt = '0; report_req = 0;
    grab(20, b, n, idl);
    check(n == 8 && b == 16'hC390, "R6", "retried word unchanged", b, 16'hC390);
    grab(20, b, n, idl);
    check(n == 8 && b == 16'h111F, "R6", "arrivals in gap form next word", b, 16'h111F);

    // pseudo-random mix against the model
    for (int i = 0; i < 3000; i++) begin
      flag_evt    = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
      report_req  = ($urandom_range(0, 15) == 0);
      report_addr = 4'($urandom);
      report_data = 8'($urandom);
      selfid_done = ($urandom_range(0, 63) == 0);
      node_id     = 6'($urandom);
      link_idle   = ($urandom_range(0, 3) != 0);
      rx_preempt  = ($urandom_range(0, 9) == 0);
      @(negedge clk);
    end
    flag_evt = '0; report_req = 0; selfid_done = 0; link_idle = 1; rx_preempt = 0;
    repeat (40) @(negedge clk);
    check(ctl == 2'b00, "R9", "quiet after drain", {30'd0, ctl}, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule